// File: doc/BRIEF.md
# Reset Strap Latch and Status Pin Mux

This block serves a set of dual-purpose configuration pins on a hub controller. While the global reset is held low, the pins are read as inputs. The value each pin carries at the last clock edge before reset goes high is frozen into a configuration bit. Those bits then stay constant until the next reset.

Once reset is released, four of the pins can become status outputs that report the state of the upstream link. They drive only while a status-output enable bit, supplied by a register elsewhere, is set. When that bit is clear, every pin keeps its output driver off and stays an input.

The frozen bits also carry the serial-bus slave address bits used when the SMBus slave interface is selected. Each downstream port's power-control pin is captured as that port's battery-charging-support bit.

Top module: `strap_status_mux`

## Requirements
- R1: While `rst_n` is low, every configuration output follows the strap pins sampled at each rising clock edge. After `rst_n` goes high, the outputs hold the values sampled at the last edge that saw `rst_n` low.
- R2: After reset release, changing any of `misc_pin_i` or `port_pin_i` leaves every configuration output unchanged until the next reset.
- R3: `cfg_i2c_mode` equals the captured `misc_pin_i[0]`. A 1 selects I2C master mode for an external EEPROM, and a 0 selects SMBus slave mode.
- R4: When `misc_pin_i[0]` was captured as 0, `cfg_smb_addr[0]` (slave address bit 1) equals the captured `misc_pin_i[1]`, and `cfg_smb_addr[1]` (slave address bit 2) equals the captured `misc_pin_i[2]`. When `misc_pin_i[0]` was captured as 1, `cfg_smb_addr` is 2'b00.
- R5: `cfg_auto_chg_en` is the inverse of the captured `misc_pin_i[3]`: a strap of 0 enables automatic charging, and a strap of 1 disables it.
- R6: `cfg_batt_sup[k]` equals the captured `port_pin_i[k]`, with 1 meaning battery charging is supported on port k.
- R7: `cfg_pwr_sw_en` is the inverse of the captured `misc_pin_i[1]`: a strap of 0 means power switching is supported. `cfg_ganged` equals the captured `misc_pin_i[2]`: a strap of 1 means ganged power control.
- R8: `misc_pin_oe` and `misc_pin_o` are all zero one clock edge after any edge that sees `rst_n` low.
- R9: After reset, an edge that samples `stat_out_en` = 0 makes `misc_pin_oe` and `misc_pin_o` all zero.
- R10: After reset, an edge that samples `stat_out_en` = 1 sets all four bits of `misc_pin_oe`. At that same edge, `misc_pin_o` takes its values from the status inputs:
  - bit 0 from `up_ss_susp`
  - bit 1 from `up_ss_conn`
  - bit 2 from `up_hs_conn`
  - bit 3 from `up_hs_susp`

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Global reset, active low; straps are sampled while it is low |
| stat_out_en | input | 1 | Register bit enabling the status outputs on the dual-purpose pins |
| up_ss_susp | input | 1 | Upstream SuperSpeed link suspended |
| up_ss_conn | input | 1 | Upstream SuperSpeed link connected |
| up_hs_conn | input | 1 | Upstream high-speed link connected |
| up_hs_susp | input | 1 | Upstream high-speed link suspended |
| misc_pin_i | input | 4 | Pad input values: [0] bus select, [1] power management, [2] ganged mode, [3] automatic charge |
| port_pin_i | input | NUM_PORTS | Pad input values of the per-port power-control pins |
| misc_pin_o | output | 4 | Pad output values of the dual-purpose pins |
| misc_pin_oe | output | 4 | Pad output enables of the dual-purpose pins |
| cfg_i2c_mode | output | 1 | 1 = I2C master, 0 = SMBus slave |
| cfg_smb_addr | output | 2 | SMBus slave address bits 2 and 1 |
| cfg_pwr_sw_en | output | 1 | Power switching supported |
| cfg_ganged | output | 1 | Ganged power control |
| cfg_auto_chg_en | output | 1 | Automatic charging mode enabled |
| cfg_batt_sup | output | NUM_PORTS | Battery charging supported, per port |

## Verification
The bench releases reset and then changes every strap pin. A design that keeps sampling after release would show the new values, so the bench compares the outputs against the pre-release pattern.

The bench uses straps whose polarity is inverted, and it runs both bus-select values. A design that drops an inversion, or that leaks the address bits while I2C mode is selected, would then give a visibly wrong bit.

It also walks each upstream status input alone, with the enable bit set. A crossed output mapping then lights the wrong pin.

Finally, it clears the enable bit and asserts reset with the status inputs high. A design that still drives in either state would show a nonzero output enable.

// File: rtl/strap_pkg.sv
package strap_pkg;

    localparam int MISC_W  = 4;
    localparam int IDX_BUS = 0;
    localparam int IDX_PWR = 1;
    localparam int IDX_GNG = 2;
    localparam int IDX_ACH = 3;

    typedef struct packed {
        logic       i2c_mode;
        logic [1:0] smb_addr;
        logic       pwr_sw_en;
        logic       ganged;
        logic       auto_chg_en;
    } cfg_t;

    function automatic cfg_t decode_straps(input logic [MISC_W-1:0] p);
        cfg_t c;
        c.i2c_mode    = p[IDX_BUS];
        c.smb_addr    = p[IDX_BUS] ? 2'b00 : {p[IDX_GNG], p[IDX_PWR]};
        c.pwr_sw_en   = ~p[IDX_PWR];
        c.ganged      = p[IDX_GNG];
        c.auto_chg_en = ~p[IDX_ACH];
        return c;
    endfunction

endpackage

// File: rtl/strap_capture.sv
module strap_capture
    import strap_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [MISC_W-1:0]    misc_pin_i,
    input  logic [NUM_PORTS-1:0] port_pin_i,
    output cfg_t                 cfg_o,
    output logic [NUM_PORTS-1:0] batt_o
);

    typedef struct packed {
        cfg_t                 cfg;
        logic [NUM_PORTS-1:0] batt;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d = cap_q;
        if (!rst_n) begin
            cap_d.cfg  = decode_straps(misc_pin_i);
            cap_d.batt = port_pin_i;
        end
    end

    always_ff @(posedge clk) begin
        cap_q <= cap_d;
    end

    assign cfg_o  = cap_q.cfg;
    assign batt_o = cap_q.batt;

    // R2: frozen once reset has been released
    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cap_q))
        else $error("strap bits changed after reset release");

    // R1: an edge seen in reset loads the port straps
    assert_load_R1: assert property (@(posedge clk)
        !rst_n |=> (batt_o == $past(port_pin_i)))
        else $error("port straps not loaded in reset");

endmodule

// File: rtl/status_drive.sv
module status_drive
    import strap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_en,
    input  logic [MISC_W-1:0] status_i,
    output logic [MISC_W-1:0] pin_o,
    output logic [MISC_W-1:0] pin_oe
);

    typedef struct packed {
        logic [MISC_W-1:0] o;
        logic [MISC_W-1:0] oe;
    } drv_t;

    drv_t drv_d, drv_q;

    always_comb begin
        drv_d = '0;
        if (rst_n) begin
            for (int i = 0; i < MISC_W; i++) begin
                drv_d.oe[i] = stat_en;
                drv_d.o[i]  = stat_en & status_i[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        drv_q <= drv_d;
    end

    assign pin_o  = drv_q.o;
    assign pin_oe = drv_q.oe;

    // R8: drivers off after any edge in reset
    assert_quiet_in_reset_R8: assert property (@(posedge clk)
        !rst_n |=> (pin_oe == '0 && pin_o == '0))
        else $error("pins driven during reset");

    // R9: drivers off while the enable is clear
    assert_off_when_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(stat_en)) |-> (pin_oe == '0 && pin_o == '0))
        else $error("pins driven with enable clear");

    // R10: status copied with one cycle of latency
    assert_status_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(stat_en)) |-> (pin_oe == '1 && pin_o == $past(status_i)))
        else $error("status output mismatch");

endmodule

// File: rtl/strap_status_mux.sv
module strap_status_mux
    import strap_pkg::*;
#(
    parameter int NUM_PORTS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stat_out_en,
    input  logic                 up_ss_susp,
    input  logic                 up_ss_conn,
    input  logic                 up_hs_conn,
    input  logic                 up_hs_susp,
    input  logic [MISC_W-1:0]    misc_pin_i,
    input  logic [NUM_PORTS-1:0] port_pin_i,
    output logic [MISC_W-1:0]    misc_pin_o,
    output logic [MISC_W-1:0]    misc_pin_oe,
    output logic                 cfg_i2c_mode,
    output logic [1:0]           cfg_smb_addr,
    output logic                 cfg_pwr_sw_en,
    output logic                 cfg_ganged,
    output logic                 cfg_auto_chg_en,
    output logic [NUM_PORTS-1:0] cfg_batt_sup
);

    cfg_t              cfg;
    logic [MISC_W-1:0] status_vec;

    // status order follows the pin each one shares
    always_comb begin
        status_vec          = '0;
        status_vec[IDX_BUS] = up_ss_susp;
        status_vec[IDX_PWR] = up_ss_conn;
        status_vec[IDX_GNG] = up_hs_conn;
        status_vec[IDX_ACH] = up_hs_susp;
    end

    strap_capture #(.NUM_PORTS(NUM_PORTS)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .misc_pin_i (misc_pin_i),
        .port_pin_i (port_pin_i),
        .cfg_o      (cfg),
        .batt_o     (cfg_batt_sup)
    );

    status_drive u_drive (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_en  (stat_out_en),
        .status_i (status_vec),
        .pin_o    (misc_pin_o),
        .pin_oe   (misc_pin_oe)
    );

    assign cfg_i2c_mode    = cfg.i2c_mode;
    assign cfg_smb_addr    = cfg.smb_addr;
    assign cfg_pwr_sw_en   = cfg.pwr_sw_en;
    assign cfg_ganged      = cfg.ganged;
    assign cfg_auto_chg_en = cfg.auto_chg_en;

    // R4: no address bits leak in I2C mode
    assert_addr_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_i2c_mode |-> (cfg_smb_addr == 2'b00))
        else $error("address bits set in I2C mode");

    // R10: enables switch as a group
    assert_oe_group_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (misc_pin_oe == '0) || (misc_pin_oe == '1))
        else $error("partial output enable");

endmodule

// File: tb/strap_status_mux_bench.sv
module strap_status_mux_bench;

    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          stat_out_en = 1'b0;
    logic          up_ss_susp = 1'b0, up_ss_conn = 1'b0, up_hs_conn = 1'b0, up_hs_susp = 1'b0;
    logic [3:0]    misc_pin_i = '0;
    logic [NP-1:0] port_pin_i = '0;
    logic [3:0]    misc_pin_o, misc_pin_oe;
    logic          cfg_i2c_mode, cfg_pwr_sw_en, cfg_ganged, cfg_auto_chg_en;
    logic [1:0]    cfg_smb_addr;
    logic [NP-1:0] cfg_batt_sup;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    strap_status_mux #(.NUM_PORTS(NP)) u_strap_status_mux (
        .clk(clk), .rst_n(rst_n), .stat_out_en(stat_out_en),
        .up_ss_susp(up_ss_susp), .up_ss_conn(up_ss_conn),
        .up_hs_conn(up_hs_conn), .up_hs_susp(up_hs_susp),
        .misc_pin_i(misc_pin_i), .port_pin_i(port_pin_i),
        .misc_pin_o(misc_pin_o), .misc_pin_oe(misc_pin_oe),
        .cfg_i2c_mode(cfg_i2c_mode), .cfg_smb_addr(cfg_smb_addr),
        .cfg_pwr_sw_en(cfg_pwr_sw_en), .cfg_ganged(cfg_ganged),
        .cfg_auto_chg_en(cfg_auto_chg_en), .cfg_batt_sup(cfg_batt_sup)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // expected configuration computed from a strap pattern
    task automatic check_cfg(input logic [3:0] p, input logic [NP-1:0] b);
        check("R3 bus select", 16'(cfg_i2c_mode), 16'(p[0]));
        check("R4 slave addr", 16'(cfg_smb_addr), p[0] ? 16'h0 : 16'({p[2], p[1]}));
        check("R5 auto charge", 16'(cfg_auto_chg_en), 16'(!p[3]));
        check("R6 batt support", 16'(cfg_batt_sup), 16'(b));
        check("R7 power switch", 16'(cfg_pwr_sw_en), 16'(!p[1]));
        check("R7 ganged", 16'(cfg_ganged), 16'(p[2]));
    endtask

    task automatic apply_reset(input logic [3:0] p, input logic [NP-1:0] b);
        @(negedge clk);
        rst_n      = 1'b0;
        misc_pin_i = p;
        port_pin_i = b;
        tick(3);
        rst_n = 1'b1;
        tick(1);
    endtask

    task automatic t_reset_state();
        // R8: in reset with status high and enable set, pins stay off
        @(negedge clk);
        rst_n = 1'b0;
        stat_out_en = 1'b1;
        {up_ss_susp, up_ss_conn, up_hs_conn, up_hs_susp} = 4'hF;
        misc_pin_i = 4'b0110;
        port_pin_i = 4'b1010;
        tick(2);
        check("R8 oe in reset", 16'(misc_pin_oe), 16'h0);
        check("R8 out in reset", 16'(misc_pin_o), 16'h0);
        // R1: outputs follow the pins while in reset
        check_cfg(4'b0110, 4'b1010);
        misc_pin_i = 4'b1001;
        port_pin_i = 4'b0101;
        tick(1);
        check("R1 track in reset", 16'(cfg_batt_sup), 16'h5);
        check_cfg(4'b1001, 4'b0101);
        stat_out_en = 1'b0;
        {up_ss_susp, up_ss_conn, up_hs_conn, up_hs_susp} = 4'h0;
    endtask

    task automatic t_capture(input logic [3:0] p, input logic [NP-1:0] b);
        apply_reset(p, b);
        check_cfg(p, b);
    endtask

    task automatic t_hold();
        // R2: pins move after release, configuration stays
        apply_reset(4'b0010, 4'b0011);
        misc_pin_i = 4'b1101;
        port_pin_i = 4'b1100;
        tick(3);
        check("R2 hold batt", 16'(cfg_batt_sup), 16'h3);
        check("R2 hold addr", 16'(cfg_smb_addr), 16'h1);
        check_cfg(4'b0010, 4'b0011);
    endtask

    task automatic t_status_off();
        // R9: enable clear, status inputs high
        apply_reset(4'b0000, 4'b0000);
        stat_out_en = 1'b0;
        {up_ss_susp, up_ss_conn, up_hs_conn, up_hs_susp} = 4'hF;
        tick(2);
        check("R9 oe off", 16'(misc_pin_oe), 16'h0);
        check("R9 out off", 16'(misc_pin_o), 16'h0);
    endtask

    task automatic t_status_on();
        // R10: walk each status input alone
        stat_out_en = 1'b1;
        for (int k = 0; k < 4; k++) begin
            up_ss_susp = (k == 0);
            up_ss_conn = (k == 1);
            up_hs_conn = (k == 2);
            up_hs_susp = (k == 3);
            tick(1);
            check("R10 oe on", 16'(misc_pin_oe), 16'hF);
            check("R10 mapping", 16'(misc_pin_o), 16'(4'b0001 << k));
        end
        // R9: clearing the enable releases the pins on the next edge
        stat_out_en = 1'b0;
        tick(1);
        check("R9 release", 16'(misc_pin_oe), 16'h0);
        check("R9 release out", 16'(misc_pin_o), 16'h0);
    endtask

    initial begin
        t_reset_state();
        t_capture(4'b0000, 4'b0000);
        t_capture(4'b1111, 4'b1111);
        t_capture(4'b0110, 4'b1001);
        t_capture(4'b1110, 4'b0110);
        t_capture(4'b0100, 4'b1000);
        t_hold();
        t_status_off();
        t_status_on();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule